// File: doc/BRIEF.md
# Processor mode and stack control

This block holds the execution state a small processor core needs around exceptions: whether the core runs in thread or handler mode, whether thread code is privileged, and which of two banked stack pointers (main or process) is in use. The core's decode and exception logic drive it with an entry strobe, a return strobe that carries a 32-bit return code, writes to a two-bit control word and explicit writes to either stack pointer. The block answers with the current mode, the effective privilege, the active stack select and the current stack pointer value.

Handler mode always runs privileged on the main stack. Thread code that has given up privilege cannot take it back by itself. The only way back is through an exception, whose handler may set the thread privilege before returning. The block checks each return code and the nesting depth, and it flags an illegal return without changing any state.

Top module: `mode_stack_ctrl`

## Requirements
- R1: After reset the block is in thread mode, privileged, on the main stack. The control readout is 2'b01 and both stack pointers read zero.
- R2: An entry strobe puts the block in handler mode from the next cycle, privileged and on the main stack, and it raises the nesting depth by one.
- R3: While in handler mode the privilege output is 1 and the process-stack select output is 0, whatever the control bits hold.
- R4: The current stack pointer equals the process stack pointer only in thread mode with control bit 1 set, and the main stack pointer otherwise. The explicit read port returns the main pointer for select 0 and the process pointer for select 1.
- R5: Control bit 0 is the thread privilege (1 = privileged). A privileged thread write to it takes effect. An unprivileged thread write that would set it leaves it at 0.
- R6: Control bit 1 picks the thread stack (1 = process, 0 = main). A control write in thread mode updates it. A control write in handler mode leaves it unchanged.
- R7: A legal return with code 0xFFFFFFF9 resumes thread mode on the main stack, and 0xFFFFFFFD resumes thread mode on the process stack. Either one sets control bit 1 to match. Code 0xFFFFFFF1 stays in handler mode. A legal return lowers the depth by one.
- R8: A return raises a one-cycle illegal flag on the next cycle and changes no state in three cases: the code is not one of the three above, the block is in thread mode, or the code is 0xFFFFFFF1 at depth 1.
- R9: A control bit 0 write made in handler mode does not change the handler's privilege. It becomes the thread privilege after a return to thread mode.
- R10: Explicit stack pointer writes store the data with its two low bits forced to 0. They are ignored while the thread is unprivileged.
- R11: When entry and return are strobed in the same cycle, entry takes effect and the return is dropped. A control write in a cycle with an entry or return strobe is dropped.
- R12: Nested entries need as many returns. After two entries, a return with 0xFFFFFFF1 is legal and a second one is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ret_code | input | 32 | Return code sampled with exc_return |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 2 | Control write data: bit 0 thread privilege, bit 1 thread stack |
| sp_we | input | 1 | Explicit stack pointer write strobe |
| sp_wsel | input | 1 | Write target: 0 main, 1 process |
| sp_wdata | input | 32 | Stack pointer write data |
| sp_rsel | input | 1 | Explicit read select: 0 main, 1 process |
| sp_rdata | output | 32 | Explicitly selected stack pointer |
| handler_o | output | 1 | 1 in handler mode |
| priv_o | output | 1 | Effective privilege |
| psp_active_o | output | 1 | 1 when the process stack is current |
| cur_sp_o | output | 32 | Current stack pointer |
| ctrl_o | output | 2 | Control word readout |
| illegal_ret_o | output | 1 | One-cycle illegal return flag |

## Verification
The bench goes after the ways privilege can leak back. If it did, an unprivileged thread that sets bit 0 would show priv_o high, or a stack write from that thread would change a pointer. A design that let handler mode follow the control bits would show the process stack or lost privilege inside a handler. The bench also checks returns at depth 1 with the handler code, unknown codes and returns from thread mode. A design that got these wrong would change mode or depth instead of raising only the flag. Same-cycle entry with return or with a control write shows whether the priority is right. A random tail mixes all of these stimuli against the reference model.

// File: rtl/mode_stack_pkg.sv
// Shared constants and types for the mode and stack controller.
// Assumes a 32-bit return code.
package mode_stack_pkg;

    localparam logic [31:0] RET_TO_HANDLER   = 32'hFFFF_FFF1;
    localparam logic [31:0] RET_THREAD_MAIN  = 32'hFFFF_FFF9;
    localparam logic [31:0] RET_THREAD_PROC  = 32'hFFFF_FFFD;

    // Classified return request
    typedef enum logic [1:0] {
        RK_BAD       = 2'd0,
        RK_HANDLER   = 2'd1,
        RK_THR_MAIN  = 2'd2,
        RK_THR_PROC  = 2'd3
    } ret_kind_t;

endpackage

// File: rtl/ret_decode.sv
// Classifies a return code into one of the three accepted requests or BAD.
// Purely combinational; assumes the caller qualifies it with the strobe.
module ret_decode
    import mode_stack_pkg::*;
(
    input  logic [31:0] code,
    output ret_kind_t   kind
);

    // Map the code value to a request kind
    always_comb begin
        unique case (code)
            RET_TO_HANDLER:  kind = RK_HANDLER;
            RET_THREAD_MAIN: kind = RK_THR_MAIN;
            RET_THREAD_PROC: kind = RK_THR_PROC;
            default:         kind = RK_BAD;
        endcase
    end

endmodule

// File: rtl/mode_ctrl.sv
// Mode, thread privilege, thread stack select and nesting depth.
// Assumes entry has priority over return, and both over control writes.
// The depth saturates at its maximum; callers keep nesting below it.
module mode_ctrl
    import mode_stack_pkg::*;
#(
    parameter int NEST_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_enter,
    input  logic       exc_return,
    input  ret_kind_t  kind,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wdata,
    output logic       handler_q,
    output logic       thr_priv_q,
    output logic       thr_psp_q,
    output logic       illegal_q
);

    localparam logic [NEST_W-1:0] NEST_MAX = {NEST_W{1'b1}};
    localparam logic [NEST_W-1:0] NEST_ONE = NEST_W'(1);

    logic [NEST_W-1:0] nest_q, nest_d;
    logic              handler_d, thr_priv_d, thr_psp_d, illegal_d;
    logic              ret_legal;

    // Decide whether a return request is acceptable in the current state
    always_comb begin
        ret_legal = 1'b0;
        if (handler_q) begin
            unique case (kind)
                RK_HANDLER:  ret_legal = (nest_q > NEST_ONE);
                RK_THR_MAIN,
                RK_THR_PROC: ret_legal = 1'b1;
                default:     ret_legal = 1'b0;
            endcase
        end
    end

    // Next-state selection by event priority
    always_comb begin
        handler_d  = handler_q;
        thr_priv_d = thr_priv_q;
        thr_psp_d  = thr_psp_q;
        nest_d     = nest_q;
        illegal_d  = 1'b0;
        if (exc_enter) begin
            handler_d = 1'b1;
            if (nest_q != NEST_MAX) nest_d = nest_q + NEST_ONE;
        end else if (exc_return) begin
            if (!ret_legal) begin
                illegal_d = 1'b1;
            end else begin
                nest_d = nest_q - NEST_ONE;
                if (kind == RK_HANDLER) begin
                    handler_d = 1'b1;
                end else begin
                    handler_d = 1'b0;
                    thr_psp_d = (kind == RK_THR_PROC);
                end
            end
        end else if (ctrl_we) begin
            if (handler_q) begin
                thr_priv_d = ctrl_wdata[0];
            end else begin
                thr_psp_d  = ctrl_wdata[1];
                thr_priv_d = thr_priv_q & ctrl_wdata[0];
            end
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q  <= 1'b0;
            thr_priv_q <= 1'b1;
            thr_psp_q  <= 1'b0;
            nest_q     <= '0;
            illegal_q  <= 1'b0;
        end else begin
            handler_q  <= handler_d;
            thr_priv_q <= thr_priv_d;
            thr_psp_q  <= thr_psp_d;
            nest_q     <= nest_d;
            illegal_q  <= illegal_d;
        end
    end

    // R2: entry always lands in handler mode
    p_enter_handler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> handler_q);

    // R5: an unprivileged thread stays unprivileged unless an exception is taken
    p_no_self_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_q && !thr_priv_q) |=> (handler_q || !thr_priv_q));

    // R8: an illegal return leaves the mode and depth untouched
    p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> ($stable(handler_q) && $stable(nest_q) && $stable(thr_psp_q)));

    // R12: handler mode always has at least one level of nesting
    p_nest_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
        handler_q |-> (nest_q != '0));

endmodule

// File: rtl/sp_bank.sv
// Two banked stack pointers with an explicit write and read port and an
// active-pointer output. The caller gates writes by privilege through wr_allow.
module sp_bank #(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_allow,
    input  logic            wr_sel,
    input  logic [SP_W-1:0] wr_data,
    input  logic            rd_sel,
    input  logic            active_sel,
    output logic [SP_W-1:0] rd_data,
    output logic [SP_W-1:0] cur_sp
);

    localparam int N_BANK = 2;

    logic [SP_W-1:0] bank_q [N_BANK];

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        // One pointer register; written when selected and allowed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && wr_allow && (wr_sel == g[0])) begin
                bank_q[g] <= {wr_data[SP_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            end
        end
    end

    // Explicit read and active pointer selection
    always_comb begin
        rd_data = bank_q[rd_sel];
        cur_sp  = bank_q[active_sel];
    end

    // R10: refused or absent writes leave both pointers unchanged
    p_sp_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_allow) |=> ($stable(bank_q[0]) && $stable(bank_q[1])));

    // R10: stored pointers keep the low bits clear
    p_sp_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q[0][ALIGN_BITS-1:0] == '0) && (bank_q[1][ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/mode_stack_ctrl.sv
// Top of the mode and stack controller. Combines the return decoder, the
// mode state and the stack pointer bank; outputs derive from registered state.
module mode_stack_ctrl #(
    parameter int SP_W   = 32,
    parameter int NEST_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_enter,
    input  logic            exc_return,
    input  logic [31:0]     ret_code,
    input  logic            ctrl_we,
    input  logic [1:0]      ctrl_wdata,
    input  logic            sp_we,
    input  logic            sp_wsel,
    input  logic [SP_W-1:0] sp_wdata,
    input  logic            sp_rsel,
    output logic [SP_W-1:0] sp_rdata,
    output logic            handler_o,
    output logic            priv_o,
    output logic            psp_active_o,
    output logic [SP_W-1:0] cur_sp_o,
    output logic [1:0]      ctrl_o,
    output logic            illegal_ret_o
);

    import mode_stack_pkg::*;

    ret_kind_t kind;
    logic      handler_q, thr_priv_q, thr_psp_q, illegal_q;

    ret_decode u_dec (
        .code (ret_code),
        .kind (kind)
    );

    mode_ctrl #(.NEST_W(NEST_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .kind       (kind),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .handler_q  (handler_q),
        .thr_priv_q (thr_priv_q),
        .thr_psp_q  (thr_psp_q),
        .illegal_q  (illegal_q)
    );

    // Effective privilege and stack choice
    always_comb begin
        handler_o     = handler_q;
        priv_o        = handler_q | thr_priv_q;
        psp_active_o  = ~handler_q & thr_psp_q;
        ctrl_o        = {thr_psp_q, thr_priv_q};
        illegal_ret_o = illegal_q;
    end

    sp_bank #(.SP_W(SP_W), .ALIGN_BITS(2)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sp_we),
        .wr_allow   (priv_o),
        .wr_sel     (sp_wsel),
        .wr_data    (sp_wdata),
        .rd_sel     (sp_rsel),
        .active_sel (psp_active_o),
        .rd_data    (sp_rdata),
        .cur_sp     (cur_sp_o)
    );

    // R3: handler mode is privileged and on the main stack
    p_handler_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        handler_o |-> (priv_o && !psp_active_o));

    // R4: the current pointer tracks the explicitly read bank of the same select
    p_cur_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_rsel == psp_active_o) |-> (cur_sp_o == sp_rdata));

endmodule

// File: tb/test_mode_stack_ctrl.sv
// Bench with a behavioural reference model compared on every clock.
module test_mode_stack_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_enter = 0, exc_return = 0, ctrl_we = 0;
    logic [31:0] ret_code = 0;
    logic [1:0]  ctrl_wdata = 0;
    logic        sp_we = 0, sp_wsel = 0, sp_rsel = 0;
    logic [31:0] sp_wdata = 0;
    logic [31:0] sp_rdata, cur_sp_o;
    logic        handler_o, priv_o, psp_active_o, illegal_ret_o;
    logic [1:0]  ctrl_o;

    always #10 clk = ~clk;

    mode_stack_ctrl i_mode_stack_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
        .ret_code(ret_code), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sp_we(sp_we), .sp_wsel(sp_wsel), .sp_wdata(sp_wdata), .sp_rsel(sp_rsel),
        .sp_rdata(sp_rdata), .handler_o(handler_o), .priv_o(priv_o),
        .psp_active_o(psp_active_o), .cur_sp_o(cur_sp_o), .ctrl_o(ctrl_o),
        .illegal_ret_o(illegal_ret_o)
    );

    // Reference model state
    bit          m_hand, m_tpriv, m_psp, m_ill;
    int          m_depth;
    logic [31:0] m_msp, m_pspv;
    int          n_checks = 0, n_fail = 0;
    bit          finished = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit e_priv, e_pspa;
        e_priv = m_hand || m_tpriv;
        e_pspa = !m_hand && m_psp;
        chk(tag, "handler", 32'(handler_o), 32'(m_hand));
        chk(tag, "priv", 32'(priv_o), 32'(e_priv));
        chk(tag, "psp_active", 32'(psp_active_o), 32'(e_pspa));
        chk(tag, "cur_sp", cur_sp_o, e_pspa ? m_pspv : m_msp);
        chk(tag, "sp_rdata", sp_rdata, sp_rsel ? m_pspv : m_msp);
        chk(tag, "ctrl", 32'(ctrl_o), 32'({m_psp, m_tpriv}));
        chk(tag, "illegal", 32'(illegal_ret_o), 32'(m_ill));
    endtask

    // Advance the model by one clock with the inputs currently applied
    task automatic model_step();
        bit pr, ok;
        pr = m_hand || m_tpriv;
        m_ill = 0;
        if (exc_enter) begin
            m_hand = 1;
            if (m_depth < 15) m_depth++;
        end else if (exc_return) begin
            ok = 0;
            if (m_hand) begin
                if (ret_code == 32'hFFFF_FFF1) ok = (m_depth > 1);
                else if (ret_code == 32'hFFFF_FFF9 || ret_code == 32'hFFFF_FFFD) ok = 1;
            end
            if (!ok) m_ill = 1;
            else begin
                m_depth--;
                if (ret_code == 32'hFFFF_FFF1) m_hand = 1;
                else begin
                    m_hand = 0;
                    m_psp = (ret_code == 32'hFFFF_FFFD);
                end
            end
        end else if (ctrl_we) begin
            if (m_hand) m_tpriv = ctrl_wdata[0];
            else begin
                m_psp = ctrl_wdata[1];
                if (m_tpriv) m_tpriv = ctrl_wdata[0];
            end
        end
        if (sp_we && pr) begin
            if (sp_wsel) m_pspv = {sp_wdata[31:2], 2'b00};
            else         m_msp  = {sp_wdata[31:2], 2'b00};
        end
    endtask

    task automatic idle_inputs();
        exc_enter = 0; exc_return = 0; ret_code = 0; ctrl_we = 0; ctrl_wdata = 0;
        sp_we = 0; sp_wsel = 0; sp_wdata = 0;
    endtask

    // Apply inputs for one cycle, step the model, compare at the next falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic do_ret(input string tag, input logic [31:0] c);
        exc_return = 1; ret_code = c; cyc(tag);
    endtask

    task automatic do_ctrl(input string tag, input logic [1:0] d);
        ctrl_we = 1; ctrl_wdata = d; cyc(tag);
    endtask

    task automatic do_sp(input string tag, input logic s, input logic [31:0] d);
        sp_we = 1; sp_wsel = s; sp_wdata = d; cyc(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_hand = 0; m_tpriv = 1; m_psp = 0; m_ill = 0; m_depth = 0; m_msp = 0; m_pspv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1");
        sp_rsel = 1; #1 compare("R1");

        // R10/R4: aligned pointer writes, explicit reads
        do_sp("R10", 1'b0, 32'h2000_0003);
        do_sp("R10", 1'b1, 32'h1000_0106);
        sp_rsel = 0; #1 compare("R4");
        // R6: thread picks process stack
        do_ctrl("R6", 2'b11);
        // R5: drop privilege, then try to take it back
        do_ctrl("R5", 2'b10);
        do_ctrl("R5", 2'b11);
        do_sp("R10", 1'b0, 32'hDEAD_BEEF);
        do_sp("R10", 1'b1, 32'h0BAD_0000);
        // R8: return from thread mode
        do_ret("R8", 32'hFFFF_FFF9);
        // R2/R3: entry forces handler on main stack
        exc_enter = 1; cyc("R2");
        sp_rsel = 1; #1 compare("R3");
        // R6/R9: handler control write, bit 1 ignored, bit 0 deferred
        do_ctrl("R9", 2'b01);
        do_sp("R10", 1'b1, 32'h3000_0011);
        // R12: nesting
        exc_enter = 1; cyc("R12");
        do_ret("R12", 32'hFFFF_FFF1);
        do_ret("R12", 32'hFFFF_FFF1);
        do_ret("R8", 32'h0000_1234);
        do_ret("R8", 32'hFFFF_FFF5);
        // R7/R9: back to thread, privileged, process stack
        do_ret("R7", 32'hFFFF_FFFD);
        // R11: entry and return together
        exc_enter = 1; exc_return = 1; ret_code = 32'hFFFF_FFF9; cyc("R11");
        do_ret("R7", 32'hFFFF_FFF9);
        // R11: entry with control write
        exc_enter = 1; ctrl_we = 1; ctrl_wdata = 2'b10; cyc("R11");
        ctrl_we = 1; ctrl_wdata = 2'b00; exc_return = 1; ret_code = 32'hFFFF_FFFD; cyc("R11");
        do_ret("R8", 32'hFFFF_FFFD);

        // Mixed random tail, R3 across all states
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            sp_rsel = 1'($urandom);
            if (r == 0 && m_depth < 6) exc_enter = 1;
            if (r == 1 || r == 2) begin
                exc_return = 1;
                case ($urandom_range(0, 3))
                    0: ret_code = 32'hFFFF_FFF1;
                    1: ret_code = 32'hFFFF_FFF9;
                    2: ret_code = 32'hFFFF_FFFD;
                    default: ret_code = $urandom;
                endcase
            end
            if (r >= 3 && r <= 5) begin ctrl_we = 1; ctrl_wdata = 2'($urandom); end
            if (r >= 5) begin sp_we = 1; sp_wsel = 1'($urandom); sp_wdata = $urandom; end
            cyc("R3");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule